// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable behavioural model of a single-clock static RAM with 32-bit words split into four byte lanes. Every address, data and control input is registered on the rising clock edge. A read delivers its word through a registered output stage, so data becomes visible one clock after the edge that captured the address. The array depth is a parameter and is kept small for simulation.

An access sequence, or burst, starts when either of two address-strobe inputs is asserted while the device is selected. After that, a 2-bit counter inside the block produces the following addresses within the aligned group of four words. The counter steps only on cycles where the advance input is asserted, and it can run in linear or interleaved order. Writes are controlled per byte lane through a lane-enable qualifier. A global write input overrides the lanes and writes the whole word. The common data bus is modelled as separate input and output vectors plus an output-drive enable.

Top module: `pburst_sram`

## Requirements
- R1: Inputs captured at clock edge k for a read access put the word on `dq_out` right after edge k+1, and that word reflects every write captured at an earlier edge.
- R2: A cycle with `proc_start_n` low is always a read, even when write inputs are active, and it takes priority when `ctrl_start_n` is low in the same cycle. A cycle started by `ctrl_start_n` alone may be a write.
- R3: While a burst is active and neither strobe is asserted, the 2-bit burst count goes up by one only when `step_n` is low. Otherwise the same address is accessed again.
- R4: With `order_ilv` low at burst start, burst step n (0..3) accesses address bits [1:0] = (start bits + n) mod 4. The upper address bits stay fixed throughout the burst.
- R5: With `order_ilv` high at burst start, burst step n accesses address bits [1:0] = start bits XOR n. The order bit is latched only when a burst starts.
- R6: With `all_wr_n` high and `lane_wr_en_n` low, each low bit `lane_wr_n[i]` writes byte lane i (`dq_in[8i+7:8i]`). The other lanes keep their value.
- R7: `all_wr_n` low writes all four lanes, whatever the values of `lane_wr_n` and `lane_wr_en_n`.
- R8: With `all_wr_n` high and `lane_wr_en_n` high, the cycle is a read and no lane of the array changes.
- R9: The device is selected only when `sel0_n`=0, `sel1`=1 and `sel2_n`=0. These inputs are sampled only on strobe cycles. A deselecting strobe ends the burst, and no access happens until the next selected strobe.
- R10: `dq_oe` is high only in the cycle after a read access is captured, and only while `out_en_n` is low. Write, idle and deselected cycles leave it low.
- R11: While `rst` is high, no burst is active and `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address, taken on strobe cycles |
| proc_start_n | input | 1 | Read burst start strobe, active low, higher priority |
| ctrl_start_n | input | 1 | Read or write burst start strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| lane_wr_n | input | 4 | Per-lane write selects, active low, bit i = lane i |
| lane_wr_en_n | input | 1 | Qualifier for lane write selects, active low |
| all_wr_n | input | 1 | Whole-word write, active low |
| out_en_n | input | 1 | Output drive enable, active low, not registered |
| dq_in | input | 32 | Write data |
| dq_out | output | 32 | Read data from the output register |
| dq_oe | output | 1 | Drive enable for the shared data bus |

## Verification
A corrupted burst count or latched order bit shows up as the wrong word on `dq_out` in the very next cycle, because the output register only adds one edge after the address register. A stuck or lost burst-active flag shows as `dq_oe` rising or falling two edges after the strobe that should have set or cleared it. A write that went to the wrong lane stays hidden until that word is read again. For that reason the array is filled with address-tagged patterns first, and stimulus returns to touched words often.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;
    localparam int CNT_W  = 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [LANES-1:0]  mask;
        logic [DATA_W-1:0] wdata;
    } access_t;

    // low address bits for burst step n from start bits s
    function automatic logic [CNT_W-1:0] burst_lsb(
        input logic [CNT_W-1:0] s,
        input logic [CNT_W-1:0] n,
        input logic             ilv
    );
        return ilv ? (s ^ n) : (s + n);
    endfunction

    // active-high lane write mask from the write controls
    function automatic logic [LANES-1:0] lane_mask(
        input logic             all_n,
        input logic             en_n,
        input logic [LANES-1:0] sel_n
    );
        if (!all_n)
            return '1;
        else if (!en_n)
            return ~sel_n;
        else
            return '0;
    endfunction

endpackage

// File: rtl/pbs_burst_ctrl.sv
module pbs_burst_ctrl
    import pbs_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                proc_start_n,
    input  logic                ctrl_start_n,
    input  logic                step_n,
    input  logic                order_ilv,
    input  logic                sel0_n,
    input  logic                sel1,
    input  logic                sel2_n,
    input  logic [LANES-1:0]    mask,
    input  logic [DATA_W-1:0]   wdata,
    output access_t             acc,
    output logic [ADDR_W-1:0]   acc_addr,
    output logic                burst_active
);

    logic               active_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   cnt_nxt;
    logic [ADDR_W-1:0]  base_q;
    logic               ilv_q;
    access_t            acc_q;
    logic [ADDR_W-1:0]  addr_q;
    logic               strobe;
    logic               picked;
    op_e                cont_op;

    always_comb begin
        strobe  = !proc_start_n || !ctrl_start_n;
        picked  = !sel0_n && sel1 && !sel2_n;
        cnt_nxt = step_n ? cnt_q : cnt_q + CNT_W'(1);
        cont_op = (mask != '0) ? OP_WRITE : OP_READ;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            base_q   <= '0;
            ilv_q    <= 1'b0;
            acc_q    <= '0;
            addr_q   <= '0;
        end else begin
            acc_q.wdata <= wdata;
            if (strobe) begin
                if (picked) begin
                    active_q <= 1'b1;
                    base_q   <= addr;
                    cnt_q    <= '0;
                    ilv_q    <= order_ilv;
                    addr_q   <= addr;
                    if (!proc_start_n) begin
                        acc_q.op   <= OP_READ;
                        acc_q.mask <= '0;
                    end else begin
                        acc_q.op   <= cont_op;
                        acc_q.mask <= mask;
                    end
                end else begin
                    active_q   <= 1'b0;
                    acc_q.op   <= OP_IDLE;
                    acc_q.mask <= '0;
                end
            end else if (active_q) begin
                cnt_q      <= cnt_nxt;
                addr_q     <= {base_q[ADDR_W-1:CNT_W],
                               burst_lsb(base_q[CNT_W-1:0], cnt_nxt, ilv_q)};
                acc_q.op   <= cont_op;
                acc_q.mask <= mask;
            end else begin
                acc_q.op   <= OP_IDLE;
                acc_q.mask <= '0;
            end
        end
    end

    assign acc          = acc_q;
    assign acc_addr     = addr_q;
    assign burst_active = active_q;

endmodule

// File: rtl/pbs_core.sv
module pbs_core
    import pbs_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int ADDR_W = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  access_t             acc,
    input  logic [ADDR_W-1:0]   acc_addr,
    output logic [DATA_W-1:0]   rd_data,
    output logic                rd_valid
);

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic [LANE_W-1:0] lane_mem [DEPTH];
            logic [LANE_W-1:0] lane_q;

            always_ff @(posedge clk) begin
                if (acc.op == OP_WRITE && acc.mask[g])
                    lane_mem[acc_addr] <= acc.wdata[g*LANE_W +: LANE_W];
                if (acc.op == OP_READ)
                    lane_q <= lane_mem[acc_addr];
            end

            assign rd_data[g*LANE_W +: LANE_W] = lane_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            rd_valid <= 1'b0;
        else
            rd_valid <= (acc.op == OP_READ);
    end

endmodule

// File: rtl/pburst_sram.sv
module pburst_sram
    import pbs_pkg::*;
#(
    parameter  int DEPTH  = 1024,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                proc_start_n,
    input  logic                ctrl_start_n,
    input  logic                step_n,
    input  logic                order_ilv,
    input  logic                sel0_n,
    input  logic                sel1,
    input  logic                sel2_n,
    input  logic [3:0]          lane_wr_n,
    input  logic                lane_wr_en_n,
    input  logic                all_wr_n,
    input  logic                out_en_n,
    input  logic [31:0]         dq_in,
    output logic [31:0]         dq_out,
    output logic                dq_oe
);

    logic [LANES-1:0]   mask;
    access_t            acc;
    logic [ADDR_W-1:0]  acc_addr;
    logic               burst_active;
    logic [DATA_W-1:0]  rd_data;
    logic               rd_valid;

    assign mask = lane_mask(all_wr_n, lane_wr_en_n, lane_wr_n);

    pbs_burst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .addr         (addr),
        .proc_start_n (proc_start_n),
        .ctrl_start_n (ctrl_start_n),
        .step_n       (step_n),
        .order_ilv    (order_ilv),
        .sel0_n       (sel0_n),
        .sel1         (sel1),
        .sel2_n       (sel2_n),
        .mask         (mask),
        .wdata        (dq_in),
        .acc          (acc),
        .acc_addr     (acc_addr),
        .burst_active (burst_active)
    );

    pbs_core #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .acc_addr (acc_addr),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assign dq_out = rd_data;
    assign dq_oe  = rd_valid && !out_en_n;

endmodule

// File: rtl/pbs_checker.sv
module pbs_checker #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              proc_start_n,
    input logic              ctrl_start_n,
    input logic              step_n,
    input logic              sel0_n,
    input logic              sel1,
    input logic              sel2_n,
    input logic              all_wr_n,
    input logic              out_en_n,
    input logic              dq_oe,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              burst_active
);

    logic strobe;
    logic picked;
    assign strobe = !proc_start_n || !ctrl_start_n;
    assign picked = !sel0_n && sel1 && !sel2_n;

    // R11: output drive off after a reset cycle
    a_r11_reset_quiet: assert property (@(posedge clk)
        rst |=> !dq_oe);

    // R3: no advance, no new strobe -> same address again
    a_r3_hold_addr: assert property (@(posedge clk) disable iff (rst)
        (burst_active && !strobe && step_n) |=> $stable(acc_addr));

    // R4: burst stays inside its aligned group of four
    a_r4_same_group: assert property (@(posedge clk) disable iff (rst)
        (burst_active && !strobe) |=> (acc_addr[ADDR_W-1:2] == $past(acc_addr[ADDR_W-1:2])));

    // R9: deselecting strobe gives no read drive
    a_r9_deselect_quiet: assert property (@(posedge clk) disable iff (rst)
        (strobe && !picked) |=> ##1 !dq_oe);

    // R7: a controller-started global write never drives the bus
    a_r7_write_quiet: assert property (@(posedge clk) disable iff (rst)
        (proc_start_n && !ctrl_start_n && picked && !all_wr_n) |=> ##1 !dq_oe);

    // R2 / R10: processor-started cycle is a read, driven per out_en_n
    a_r10_read_drive: assert property (@(posedge clk) disable iff (rst)
        (!proc_start_n && picked) |=> ##1 (dq_oe == !out_en_n));

endmodule

bind pburst_sram pbs_checker #(.ADDR_W(ADDR_W)) u_pbs_chk (
    .clk          (clk),
    .rst          (rst),
    .proc_start_n (proc_start_n),
    .ctrl_start_n (ctrl_start_n),
    .step_n       (step_n),
    .sel0_n       (sel0_n),
    .sel1         (sel1),
    .sel2_n       (sel2_n),
    .all_wr_n     (all_wr_n),
    .out_en_n     (out_en_n),
    .dq_oe        (dq_oe),
    .acc_addr     (acc_addr),
    .burst_active (burst_active)
);

// File: tb/pburst_sram_bench.sv
module pburst_sram_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam int AW         = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          proc_start_n = 1'b1, ctrl_start_n = 1'b1, step_n = 1'b1, order_ilv = 1'b0;
    logic          sel0_n = 1'b0, sel1 = 1'b1, sel2_n = 1'b0;
    logic [3:0]    lane_wr_n = 4'hF;
    logic          lane_wr_en_n = 1'b1, all_wr_n = 1'b1, out_en_n = 1'b0;
    logic [31:0]   dq_in = '0;
    logic [31:0]   dq_out;
    logic          dq_oe;

    int n_chk  = 0;
    int n_fail = 0;
    string cur_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    pburst_sram #(.DEPTH(DEPTH)) u_pburst_sram (
        .clk(clk), .rst(rst), .addr(addr),
        .proc_start_n(proc_start_n), .ctrl_start_n(ctrl_start_n),
        .step_n(step_n), .order_ilv(order_ilv),
        .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
        .lane_wr_n(lane_wr_n), .lane_wr_en_n(lane_wr_en_n), .all_wr_n(all_wr_n),
        .out_en_n(out_en_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // ---------------- reference model ----------------
    logic [31:0]   m_mem [DEPTH];
    logic          m_active = 1'b0, m_ilv = 1'b0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;
    int            s1_op = 0;          // 0 idle, 1 read, 2 write
    logic [AW-1:0] s1_addr = '0;
    logic [3:0]    s1_mask = '0;
    logic [31:0]   s1_data = '0;
    logic          o_rd = 1'b0;
    logic [31:0]   o_data = '0;

    function automatic logic [31:0] pat(input int a);
        return 32'hA500_0000 | a;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        logic       st;
        logic [3:0] mk;
        logic [1:0] lsb;
        if (rst) begin
            m_active = 1'b0; s1_op = 0; o_rd = 1'b0;
            return;
        end
        if (s1_op == 1) begin o_rd = 1'b1; o_data = m_mem[s1_addr]; end
        else o_rd = 1'b0;
        if (s1_op == 2)
            for (int i = 0; i < 4; i++)
                if (s1_mask[i]) m_mem[s1_addr][i*8 +: 8] = s1_data[i*8 +: 8];
        st = !proc_start_n || !ctrl_start_n;
        mk = !all_wr_n ? 4'hF : (!lane_wr_en_n ? ~lane_wr_n : 4'h0);
        if (st) begin
            if (!sel0_n && sel1 && !sel2_n) begin
                m_active = 1'b1; m_base = addr; m_cnt = 2'd0; m_ilv = order_ilv;
                s1_addr = addr;
                if (!proc_start_n || mk == 4'h0) begin s1_op = 1; s1_mask = 4'h0; end
                else begin s1_op = 2; s1_mask = mk; end
            end else begin
                m_active = 1'b0; s1_op = 0;
            end
        end else if (m_active) begin
            if (!step_n) m_cnt = m_cnt + 2'd1;
            lsb = m_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
            s1_addr = {m_base[AW-1:2], lsb};
            s1_op = (mk == 4'h0) ? 1 : 2;
            s1_mask = mk;
        end else begin
            s1_op = 0;
        end
        s1_data = dq_in;
    endtask

    task automatic model_cmp();
        logic eo;
        eo = o_rd && !out_en_n;
        chk("R10 drive enable", {31'd0, dq_oe}, {31'd0, eo});
        if (eo) chk(cur_tag, dq_out, o_data);
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        model_cmp();
    endtask

    task automatic idle();
        proc_start_n = 1'b1; ctrl_start_n = 1'b1; step_n = 1'b1;
        lane_wr_n = 4'hF; lane_wr_en_n = 1'b1; all_wr_n = 1'b1;
        sel0_n = 1'b0; sel1 = 1'b1; sel2_n = 1'b0; out_en_n = 1'b0;
    endtask

    task automatic do_write(input int a, input logic [31:0] d,
                            input logic an, input logic en, input logic [3:0] ln);
        idle();
        ctrl_start_n = 1'b0; addr = AW'(a); dq_in = d;
        all_wr_n = an; lane_wr_en_n = en; lane_wr_n = ln;
        tick();
        idle();
    endtask

    task automatic do_read(input int a, input string tag, input logic [31:0] exp);
        idle();
        proc_start_n = 1'b0; addr = AW'(a);
        tick();
        idle();
        tick();
        chk(tag, dq_out, exp);
    endtask

    // start a read burst, then three steps; compare the four words
    task automatic burst(input int a, input logic ilv, input logic [3:0] steps_n,
                         input int e0, input int e1, input int e2, input int e3,
                         input string tag);
        int e [4];
        e[0] = e0; e[1] = e1; e[2] = e2; e[3] = e3;
        idle();
        proc_start_n = 1'b0; addr = AW'(a); order_ilv = ilv;
        tick();
        for (int i = 1; i <= 4; i++) begin
            idle();
            order_ilv = ~ilv;          // order is latched at start only
            step_n = (i <= 3) ? steps_n[i-1] : 1'b1;
            tick();
            chk(tag, dq_out, pat(e[i-1]));
        end
        order_ilv = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2741));
        idle();
        rst = 1'b1;
        tick(); tick(); tick();
        chk("R11 reset oe", {31'd0, dq_oe}, 32'd0);
        rst = 1'b0;

        // fill array with address-tagged words (global write, R7)
        cur_tag = "R7 fill";
        for (int a = 0; a < DEPTH; a++) do_write(a, pat(a), 1'b0, 1'b1, 4'hF);
        tick();

        cur_tag = "R1 latency";
        do_read(3, "R1 read after write", pat(3));

        // burst orders (R4, R5) and hold (R3)
        cur_tag = "R4";
        burst(5, 1'b0, 3'b000, 5, 6, 7, 4, "R4 linear burst");
        cur_tag = "R5";
        burst(9, 1'b1, 3'b000, 9, 8, 11, 10, "R5 interleaved burst");
        burst(14, 1'b1, 3'b000, 14, 15, 12, 13, "R5 interleaved from 2");
        cur_tag = "R3";
        burst(13, 1'b0, 3'b011, 13, 13, 13, 14, "R3 hold without advance");

        // byte lanes (R6)
        cur_tag = "R6";
        do_write(20, 32'h1122_3344, 1'b1, 1'b0, 4'b1010);
        do_read(20, "R6 lanes 0 and 2", 32'hA522_0044);
        do_write(24, 32'hFFFF_FFFF, 1'b1, 1'b0, 4'b0111);
        do_read(24, "R6 lane 3 only", 32'hFF00_0018);

        // global override (R7)
        cur_tag = "R7";
        do_write(21, 32'hDEAD_BEEF, 1'b0, 1'b1, 4'hF);
        do_read(21, "R7 global ignores lanes", 32'hDEAD_BEEF);

        // lane qualifier off -> read, no change (R8)
        cur_tag = "R8";
        do_write(22, 32'h0000_0000, 1'b1, 1'b1, 4'h0);
        do_read(22, "R8 unqualified lanes", pat(22));

        // processor strobe wins and reads (R2)
        cur_tag = "R2";
        idle();
        proc_start_n = 1'b0; ctrl_start_n = 1'b0; all_wr_n = 1'b0;
        addr = AW'(23); dq_in = 32'h0;
        tick();
        idle();
        tick();
        chk("R2 priority read oe", {31'd0, dq_oe}, 32'd1);
        chk("R2 priority read data", dq_out, pat(23));
        do_read(23, "R2 no write on priority cycle", pat(23));

        // deselect (R9)
        cur_tag = "R9";
        idle(); proc_start_n = 1'b0; addr = AW'(30); tick();
        idle(); ctrl_start_n = 1'b0; sel1 = 1'b0; tick();
        idle(); tick();
        chk("R9 deselect no drive", {31'd0, dq_oe}, 32'd0);
        tick();
        chk("R9 burst ended", {31'd0, dq_oe}, 32'd0);
        idle(); proc_start_n = 1'b0; addr = AW'(32); tick();
        idle(); sel0_n = 1'b1; step_n = 1'b0; tick();
        idle(); sel0_n = 1'b1; tick();
        chk("R9 selects ignored mid-burst", dq_out, pat(33));

        // output enable gating (R10)
        cur_tag = "R10";
        idle(); proc_start_n = 1'b0; addr = AW'(40); tick();
        idle(); out_en_n = 1'b1; tick();
        chk("R10 oe gated off", {31'd0, dq_oe}, 32'd0);
        out_en_n = 1'b0;
        #1;
        chk("R10 oe gated on", {31'd0, dq_oe}, 32'd1);
        chk("R10 data", dq_out, pat(40));

        // constrained random traffic, checked by the model (R1..R10)
        cur_tag = "R1 random";
        for (int c = 0; c < 4000; c++) begin
            int r;
            r = int'($urandom % 100);
            proc_start_n = !(r < 10);
            ctrl_start_n = !(r >= 10 && r < 24);
            step_n = $urandom % 2;
            order_ilv = $urandom % 2;
            addr = AW'($urandom);
            dq_in = $urandom;
            all_wr_n = ($urandom % 5) != 0;
            lane_wr_en_n = $urandom % 2;
            lane_wr_n = 4'($urandom);
            out_en_n = ($urandom % 8) == 0;
            sel0_n = 1'b0; sel1 = 1'b1; sel2_n = 1'b0;
            if (($urandom % 8) == 0) begin
                case ($urandom % 3)
                    0: sel0_n = 1'b1;
                    1: sel1 = 1'b0;
                    default: sel2_n = 1'b1;
                endcase
            end
            tick();
        end

        idle();
        tick();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule